// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit with Signed Set-Less-Than

This block is a purely combinational arithmetic logic unit of parameterised width (32 bits by default). It is built as a chain of identical one-bit slices. Each slice has a full adder and a small result selector. A 3-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or set-on-less-than. Next to the result the block reports a zero flag, a signed overflow flag and the adder carry-out.

The top bit of the operation code is a negate-b control. In every slice it replaces the second operand with its complement, and it enters the carry chain as a carry-in of one, so the adder computes a + ~b + 1. For set-on-less-than the sum bit of the top slice is routed back as the "less" input of the bottom slice. Every other slice selects a constant zero. The result is therefore the sign bit of a - b exactly as the adder produces it, and that bit is wrong whenever the subtraction overflows.

Top module: `chain_alu`

## Requirements
- R1: Code 3'b000 gives result = a & b, bit by bit.
- R2: Code 3'b001 gives result = a | b, bit by bit.
- R3: Code 3'b010 gives result = (a + b) mod 2^W, and carry_out is the carry leaving bit W-1 of that sum.
- R4: Code 3'b110 gives result = (a + ~b + 1) mod 2^W, and carry_out is the carry leaving bit W-1 of that sum (1 when a >= b unsigned).
- R5: Code 3'b111 gives result bit 0 equal to bit W-1 of (a + ~b + 1) mod 2^W, with all other result bits 0. This is the raw sign bit, even when the subtraction overflows.
- R6: For codes 3'b010 and 3'b110, overflow is 1 exactly when the carry into bit W-1 differs from the carry out of bit W-1. For every other code it is 0.
- R7: carry_out is 0 for every code other than 3'b010 and 3'b110.
- R8: Codes 3'b011, 3'b100 and 3'b101 give a result of all zeros.
- R9: zero is 1 exactly when every bit of result is 0, for all codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ctrl | input | 3 | Operation code; bit 2 is negate-b |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the top slice for add or subtract |

## Verification
The set-on-less-than result and the overflow condition come from the same subtraction in the same evaluation. The bench drives operand pairs that overflow on a - b, such as the most negative value against a positive one and the most positive value against a negative one. It expects the wired sign bit to appear as the comparison result, and it expects the overflow flag to stay low because overflow is only reported for add and subtract. The same pairs are then applied under the subtract code, where overflow must rise. Set-less-than results of zero are also checked against the zero flag.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // per-slice result selector
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       valid;
        logic       negate_b;
        logic       arith;
        slice_sel_e sel;
    } alu_ctl_t;
endpackage

// File: rtl/chain_alu_decode.sv
module chain_alu_decode
    import chain_alu_pkg::*;
(
    input  logic [2:0] ctrl,
    output alu_ctl_t   ctl
);
    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d          = '0;
        ctl_d.negate_b = ctrl[2];
        ctl_d.sel      = slice_sel_e'(ctrl[1:0]);
        unique case (ctrl)
            OP_AND, OP_OR, OP_SLT: ctl_d.valid = 1'b1;
            OP_ADD, OP_SUB: begin
                ctl_d.valid = 1'b1;
                ctl_d.arith = 1'b1;
            end
            default: ctl_d.valid = 1'b0;
        endcase
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/chain_alu_slice.sv
module chain_alu_slice
    import chain_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       less,
    input  logic       negate_b,
    input  slice_sel_e sel,
    output logic       res,
    output logic       sum,
    output logic       cout
);
    logic b_eff;

    always_comb begin
        b_eff = b ^ negate_b;
        sum   = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (cin & (a ^ b_eff));
        unique case (sel)
            SEL_AND:  res = a & b;
            SEL_OR:   res = a | b;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/chain_alu_zero.sv
module chain_alu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);
    assign all_zero = ~|vec;
endmodule

// File: rtl/chain_alu.sv
module chain_alu
    import chain_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic             carry [WIDTH+1];
    logic             sum_bit [WIDTH];
    logic             res_bit [WIDTH];
    logic [WIDTH-1:0] result_d;
    logic             set_msb;

    chain_alu_decode u_decode (
        .ctrl (ctrl),
        .ctl  (ctl)
    );

    assign carry[0] = ctl.negate_b;
    assign set_msb  = sum_bit[MSB];

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            assign less_in = set_msb;
        end else begin : g_upper
            assign less_in = 1'b0;
        end

        chain_alu_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .cin      (carry[i]),
            .less     (less_in),
            .negate_b (ctl.negate_b),
            .sel      (ctl.sel),
            .res      (res_bit[i]),
            .sum      (sum_bit[i]),
            .cout     (carry[i+1])
        );

        assign result_d[i] = res_bit[i] & ctl.valid;
    end

    assign result    = result_d;
    assign overflow  = ctl.arith & (carry[MSB] ^ carry[WIDTH]);
    assign carry_out = ctl.arith & carry[WIDTH];

    chain_alu_zero #(.WIDTH(WIDTH)) u_zero (
        .vec      (result_d),
        .all_zero (zero)
    );
endmodule

// File: rtl/chain_alu_checker.sv
module chain_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       ctrl,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry_out
);
    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;

    always_comb begin
        add_ref = {1'b0, a} + {1'b0, b};
        sub_ref = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        if (ctrl == 3'b000) a_r1_and: assert (result == (a & b));
        if (ctrl == 3'b001) a_r2_or: assert (result == (a | b));
        if (ctrl == 3'b010) a_r3_add: assert ({carry_out, result} == add_ref);
        if (ctrl == 3'b110) a_r4_sub: assert ({carry_out, result} == sub_ref);
        if (ctrl == 3'b111) a_r5_slt_upper: assert (result[WIDTH-1:1] == '0);
        if (ctrl != 3'b010 && ctrl != 3'b110) begin
            a_r6_no_overflow: assert (!overflow);
            a_r7_no_carry: assert (!carry_out);
        end
        if (ctrl == 3'b011 || ctrl == 3'b100 || ctrl == 3'b101)
            a_r8_invalid_zero: assert (result == '0);
        a_r9_zero_flag: assert (zero == (result == '0));
    end
endmodule

bind chain_alu chain_alu_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/chain_alu_bench.sv
module chain_alu_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, result;
    logic [2:0]   ctrl;
    logic         zero, overflow, carry_out;
    int           checks = 0;
    int           failures = 0;

    always #10 clk = ~clk;

    chain_alu #(.WIDTH(W)) u_chain_alu (
        .a(a), .b(b), .ctrl(ctrl), .result(result),
        .zero(zero), .overflow(overflow), .carry_out(carry_out)
    );

    task automatic expect_bit(input string tag, input string what,
                              input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // apply one operation and compare every output with the bench model
    task automatic apply(input string tag, input logic [2:0] op,
                         input logic [W-1:0] xa, input logic [W-1:0] xb);
        logic [W:0]   s;
        logic [W-1:0] er;
        logic         ec, eo;
        @(posedge clk);
        a = xa; b = xb; ctrl = op;
        er = '0; ec = 1'b0; eo = 1'b0;
        case (op)
            3'b000: er = xa & xb;
            3'b001: er = xa | xb;
            3'b010: begin
                s = {1'b0, xa} + {1'b0, xb};
                er = s[W-1:0]; ec = s[W];
                eo = (xa[W-1] == xb[W-1]) && (er[W-1] != xa[W-1]);
            end
            3'b110: begin
                s = {1'b0, xa} + {1'b0, ~xb} + 1;
                er = s[W-1:0]; ec = s[W];
                eo = (xa[W-1] != xb[W-1]) && (er[W-1] != xa[W-1]);
            end
            3'b111: begin
                s = {1'b0, xa} + {1'b0, ~xb} + 1;
                er = {{(W-1){1'b0}}, s[W-1]};
            end
            default: er = '0;
        endcase
        @(negedge clk);
        checks++;
        if (result !== er) begin
            failures++;
            $display("FAIL %s result actual=%h expected=%h", tag, result, er);
        end
        expect_bit(tag, "carry_out", carry_out, ec);
        expect_bit(tag, "overflow", overflow, eo);
        expect_bit("R9", "zero", zero, (er == '0));
    endtask

    task automatic t_idle;
        apply("R1", 3'b000, '0, '0);
    endtask

    task automatic t_logic;
        apply("R1", 3'b000, 32'hF0F0_1234, 32'hFF00_FF0F);
        apply("R1", 3'b000, 32'hFFFF_FFFF, 32'h8000_0000);
        apply("R2", 3'b001, 32'h0F0F_0000, 32'h0000_1234);
        apply("R2", 3'b001, 32'h0000_0000, 32'h0000_0000);
        apply("R7", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_add;
        apply("R3", 3'b010, 32'd5, 32'd7);
        apply("R3", 3'b010, 32'hFFFF_FFFF, 32'd1);
        apply("R6", 3'b010, 32'h7FFF_FFFF, 32'd1);
        apply("R6", 3'b010, 32'h8000_0000, 32'h8000_0000);
    endtask

    task automatic t_sub;
        apply("R4", 3'b110, 32'd9, 32'd9);
        apply("R4", 3'b110, 32'd3, 32'd10);
        apply("R4", 3'b110, 32'h0000_0000, 32'hFFFF_FFFF);
        apply("R6", 3'b110, 32'h8000_0000, 32'd1);
        apply("R6", 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_slt;
        apply("R5", 3'b111, 32'd3, 32'd10);
        apply("R5", 3'b111, 32'd10, 32'd3);
        apply("R5", 3'b111, 32'hFFFF_FFFF, 32'd0);
        // overflowing subtractions: wired sign bit is reported as is
        apply("R5", 3'b111, 32'h8000_0000, 32'd1);
        apply("R5", 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply("R5", 3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    endtask

    task automatic t_invalid;
        apply("R8", 3'b011, 32'h8000_0000, 32'd1);
        apply("R8", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply("R8", 3'b101, 32'h1234_5678, 32'h0F0F_0F0F);
    endtask

    task automatic t_random;
        logic [W-1:0] edges [4];
        logic [2:0]   ops [5];
        edges = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'hFFFF_FFFF};
        ops   = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
        for (int o = 0; o < 5; o++) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply("R3", ops[o], edges[i], edges[j]);
            for (int k = 0; k < 40; k++)
                apply("R4", ops[o], $urandom, $urandom);
        end
    endtask

    initial begin
        a = '0; b = '0; ctrl = '0;
        t_idle();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_invalid();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule